// File: doc/BRIEF.md
# Nibble Port Expander Strobe Sequencer

This block runs accesses to an external four-bit port expander over four shared pins and one active-low strobe. Each access begins with a control nibble on the pins. The control nibble packs an operation and one of four expander ports. The strobe then goes low. After a hold window the pins either carry the write nibble or are released so the expander can drive them. The block samples the returned nibble in the last clock before the strobe goes high again.

A requester presents an operation, a port number and a write nibble with a valid flag. The block takes the request when it is idle and raises busy until the access is over. A request that arrives while busy is not dropped. The requester keeps it presented, and the block takes it after the current access has finished. The setup window, hold window, pulse width and trailing data hold are counted in internal clocks and set by parameters.

Top module: `xp_strobe_top`

## Requirements
- R1: After reset and whenever no access is running: the strobe is high, the pin enable is low, busy is low and the read-done pulse is low.
- R2: After a request is taken, the pins are driven for SETUP_CYC cycles with the strobe high. The driven value is the control nibble: bits 3:2 hold the operation (00 read, 01 write, 10 OR, 11 AND) and bits 1:0 hold the port select (00..11 for expander ports 4..7).
- R3: The strobe is low for exactly PULSE_CYC consecutive cycles. It starts SETUP_CYC cycles after the request is taken.
- R4: The control nibble stays driven for the first HOLD_CYC cycles of the low strobe.
- R5: For write, OR and AND, the write nibble is driven from strobe cycle HOLD_CYC to the end of the pulse. It stays driven for TAIL_CYC more cycles after the strobe rises.
- R6: For a read, the pin enable is low from strobe cycle HOLD_CYC through the TAIL_CYC cycles after the strobe rises.
- R7: A read captures the pin input at the clock edge where the strobe rises, so only the value in the last low cycle counts. The captured nibble is shown on the read-data output while read-done is high for exactly one cycle, the first cycle after the strobe rises.
- R8: Busy is high from the cycle after a request is taken until the access ends. A request held during busy is not lost. It is taken after one idle cycle, and its control nibble appears only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until taken |
| reqOp | input | 2 | Operation: 00 read, 01 write, 10 OR, 11 AND |
| reqPort | input | 2 | Expander port select (ports 4..7) |
| reqData | input | 4 | Write nibble |
| nibIn | input | 4 | Pin input value |
| nibOut | output | 4 | Pin drive value |
| nibOe | output | 1 | Pin drive enable |
| progN | output | 1 | Expander strobe, active low, idles high |
| busy | output | 1 | Access in progress |
| rdDone | output | 1 | One-cycle pulse with a read result |
| rdData | output | 4 | Last read nibble |

## Verification
Every output is timed from the clock edge that takes the request. With the defaults, this is the timing:
- The control nibble shows in cycles 1 and 2.
- The strobe is low in cycles 3 to 12, with the control nibble still driven in cycles 3 to 6.
- Write data or a released bus fills cycles 7 to 14.
- The read result and read-done appear in cycle 13.
- The first idle cycle is cycle 15.

The bench counts cycles from the taking edge and samples on the falling clock edge in each of those cycles. It compares against values derived from the cycle index and the operation. During the pulse it drives the inverse of the expected read nibble on the pin input, except in the last low cycle. A sample taken too early therefore shows up as a mismatch.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_OR    = 2'b10,
    OP_AND   = 2'b11
  } xpOp_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_TAIL
  } xpPhase_e;

  typedef struct packed {
    logic load;       // take the presented request
    logic progLow;    // strobe asserted
    logic driveCtrl;  // pins carry control nibble
    logic driveData;  // pins carry write nibble
    logic sample;     // capture pin input at this edge
  } xpStrobe_t;
endpackage

// File: rtl/xp_ctrl.sv
module xp_ctrl
  import xp_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 4,
  parameter int PULSE_CYC = 10,
  parameter int TAIL_CYC  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isRead,
  output logic      busy,
  output xpStrobe_t stb
);
  localparam int MAXC  = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int CNT_W = $clog2(MAXC + TAIL_CYC + 1);

  xpPhase_e phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (reqValid) phase <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_STROBE: begin
          if (cnt == CNT_W'(PULSE_CYC - 1)) begin
            phase <= PH_TAIL;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_TAIL: begin
          if (cnt == CNT_W'(TAIL_CYC - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic inHold;
  assign inHold = (phase == PH_STROBE) && (cnt < CNT_W'(HOLD_CYC));

  always_comb begin
    stb.load      = (phase == PH_IDLE) && reqValid;
    stb.progLow   = (phase == PH_STROBE);
    stb.driveCtrl = (phase == PH_SETUP) || inHold;
    stb.driveData = !isRead && (((phase == PH_STROBE) && !inHold) || (phase == PH_TAIL));
    stb.sample    = isRead && (phase == PH_STROBE) && (cnt == CNT_W'(PULSE_CYC - 1));
  end

  assign busy = (phase != PH_IDLE);

  // Independent run-length counter of the strobe-low window
  logic [CNT_W-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else       lowRun <= stb.progLow ? lowRun + 1'b1 : '0;
  end

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.progLow) |-> lowRun == CNT_W'(PULSE_CYC));
  p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= CNT_W'(PULSE_CYC));
  p_busy_from_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  p_drive_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.driveCtrl && stb.driveData));
endmodule

// File: rtl/xp_datapath.sv
module xp_datapath
  import xp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  xpStrobe_t        stb,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqPort,
  input  logic [NIB_W-1:0] reqData,
  input  logic [NIB_W-1:0] nibIn,
  output logic             isRead,
  output logic [NIB_W-1:0] nibOut,
  output logic             nibOe,
  output logic             progN,
  output logic             rdDone,
  output logic [NIB_W-1:0] rdData
);
  xpOp_e            opReg;
  logic [1:0]       portReg;
  logic [NIB_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_READ;
      portReg <= '0;
      dataReg <= '0;
    end else if (stb.load) begin
      opReg   <= xpOp_e'(reqOp);
      portReg <= reqPort;
      dataReg <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDone <= 1'b0;
      rdData <= '0;
    end else begin
      rdDone <= stb.sample;
      if (stb.sample) rdData <= nibIn;
    end
  end

  assign isRead = (opReg == OP_READ);
  assign nibOe  = stb.driveCtrl | stb.driveData;
  assign nibOut = stb.driveData ? dataReg : {opReg, portReg};
  assign progN  = !stb.progLow;

  p_read_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> !nibOe);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);
  p_done_at_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> $rose(progN));
endmodule

// File: rtl/xp_strobe_top.sv
module xp_strobe_top
  import xp_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 4,
  parameter int PULSE_CYC = 10,
  parameter int TAIL_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqPort,
  input  logic [3:0] reqData,
  input  logic [3:0] nibIn,
  output logic [3:0] nibOut,
  output logic       nibOe,
  output logic       progN,
  output logic       busy,
  output logic       rdDone,
  output logic [3:0] rdData
);
  xpStrobe_t stb;
  logic      isRead;

  xp_ctrl #(
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .PULSE_CYC(PULSE_CYC), .TAIL_CYC(TAIL_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isRead(isRead),
    .busy(busy), .stb(stb)
  );

  xp_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqPort(reqPort),
    .reqData(reqData), .nibIn(nibIn), .isRead(isRead), .nibOut(nibOut),
    .nibOe(nibOe), .progN(progN), .rdDone(rdDone), .rdData(rdData)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (progN && !nibOe && !rdDone));
  p_prog_fall_ctrl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progN) |-> nibOe);
endmodule

// File: tb/tb_xp_strobe_top.sv
module tb_xp_strobe_top;
  localparam int S = 2, H = 4, P = 10, T = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0, reqPort = '0;
  logic [3:0] reqData = '0, nibIn = '0;
  logic [3:0] nibOut, rdData;
  logic nibOe, progN, busy, rdDone;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  xp_strobe_top #(.SETUP_CYC(S), .HOLD_CYC(H), .PULSE_CYC(P), .TAIL_CYC(T)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPort(reqPort),
    .reqData(reqData), .nibIn(nibIn), .nibOut(nibOut), .nibOe(nibOe),
    .progN(progN), .busy(busy), .rdDone(rdDone), .rdData(rdData)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(req, progN, 1);
    chk(req, nibOe, 0);
    chk(req, busy, 0);
    chk(req, rdDone, 0);
  endtask

  // Called at a negedge with the block idle; ends at the first idle negedge.
  task automatic runAccess(input logic [1:0] op, input logic [1:0] port,
                           input logic [3:0] data, input logic [3:0] inNib,
                           input bit hasNext, input logic [1:0] nOp,
                           input logic [1:0] nPort, input logic [3:0] nData);
    bit rd;
    rd = (op == 2'b00);
    chkIdle("R1 idle before access");
    reqValid = 1'b1; reqOp = op; reqPort = port; reqData = data;
    nibIn = ~inNib;
    @(posedge clk);
    for (int i = 1; i <= S + P + T; i++) begin
      int expProg, expOe, expOut, j;
      @(negedge clk);
      expProg = (i > S && i <= S + P) ? 0 : 1;
      expOe = 1; expOut = {op, port};
      if (i > S && i <= S + P) begin
        j = i - S - 1;
        if (j >= H) begin expOe = rd ? 0 : 1; expOut = data; end
      end else if (i > S + P) begin
        expOe = rd ? 0 : 1; expOut = data;
      end
      chk("R3 strobe level", progN, expProg);
      chk("R8 busy during access", busy, 1);
      if (i <= S) chk("R2 control drive", nibOe, 1);
      else if (i <= S + H) chk("R4 control hold", nibOe, 1);
      else if (rd) chk("R6 read release", nibOe, 0);
      else chk("R5 data drive", nibOe, 1);
      if (expOe == 1) begin
        if (i <= S + H) chk("R2 control nibble", nibOut, expOut);
        else chk("R5 write nibble", nibOut, expOut);
      end
      chk("R7 done pulse", rdDone, (rd && i == S + P + 1) ? 1 : 0);
      if (rd && i == S + P + 1) chk("R7 read data", rdData, inNib);
      if (i == 1) begin
        reqValid = hasNext;
        if (hasNext) begin reqOp = nOp; reqPort = nPort; reqData = nData; end
      end
      nibIn = (i == S + P) ? inNib : ~inNib;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset");
    // Full sweep of operations, ports and nibbles
    for (int op = 0; op < 4; op++)
      for (int pt = 0; pt < 4; pt++)
        for (int d = 0; d < 16; d++)
          runAccess(2'(op), 2'(pt), 4'(d), 4'(d ^ (pt * 5)), 1'b0, 2'b0, 2'b0, 4'b0);
    // R8: requests held while busy are taken after one idle cycle
    runAccess(2'b01, 2'b10, 4'hA, 4'h0, 1'b1, 2'b00, 2'b11, 4'h0);
    chk("R8 idle gap before held request", busy, 0);
    runAccess(2'b00, 2'b11, 4'h0, 4'h6, 1'b1, 2'b11, 2'b01, 4'h9);
    chk("R8 idle gap before held request", busy, 0);
    runAccess(2'b11, 2'b01, 4'h9, 4'h0, 1'b0, 2'b0, 2'b0, 4'b0);
    reqValid = 1'b0;
    @(negedge clk);
    chkIdle("R1 quiet after last access");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule